// File: doc/BRIEF.md
# Dual-layout MDIO management controller

This block is the register front-end of a MAC's PHY management port. Software writes a command word into a control register. The block then runs one Clause 22 read or write frame on the MDC/MDIO pins. When the frame ends, the command bits clear themselves, and for a read the 16-bit result is written into the data register.

Two bit layouts are defined for the control and data registers. Bit 31 of a feature register picks the layout at run time. The layout in force when a command is accepted applies to that command until it ends, even if the feature register is rewritten while the frame is running.

Software uses a simple 32-bit write port and a combinational read port, selected by a 2-bit register address. A `busy` output is high while a frame is in flight. A one-cycle `cmd_err` pulse marks a command word that cannot start a frame.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Register select 0 is control, 1 is data and 2 is the feature register. A feature write stores all 32 bits, which read back unchanged. Feature bit 31 = 1 selects the new layout and 0 selects the legacy layout.
- R2: New layout, control word fields are: write data [31:16], fire [15], Clause 22 flag [12], opcode [11:10], PHY address [9:5], register address [4:0]. With fire = 1, flag = 1 and opcode 01, one write frame carries these fields. Fire reads back as 0 after completion.
- R3: New layout, opcode 10 with fire and flag set runs a read frame. The data register then holds the 16 read bits in [15:0], with [31:16] = 0, and fire reads back as 0.
- R4: New layout, opcode 00 or 11 with fire and flag set runs no frame. It pulses `cmd_err` for one cycle in the cycle after the write, leaves `busy` low, and stores the word with fire cleared.
- R5: New layout, a word with the flag clear or fire clear runs no frame and raises no error. It is stored unchanged.
- R6: Legacy layout, control bit 27 = 1 runs a write frame with PHY address [25:21], register address [4:0] and the data register's bits [15:0]. Bit 27 reads back as 0 afterwards.
- R7: Legacy layout, control bit 26 = 1 (with bit 27 = 0) runs a read frame. The data register then holds the result in [31:16], with [15:0] = 0, and bit 26 reads back as 0.
- R8: Legacy layout, with bits 27 and 26 both set, only a write frame runs. Bit 27 clears and bit 26 stays set.
- R9: Legacy layout, with neither bit 27 nor bit 26 set, no frame runs and `cmd_err` pulses for one cycle.
- R10: A frame is 64 MDC periods, sent MSB first: 32 ones, start 01, opcode (01 write, 10 read), PHY address, register address, turnaround, 16 data bits. Writes send turnaround 10 and keep `mdio_oe` high for the whole frame. Reads drop `mdio_oe` from the turnaround to the end of the frame and sample `mdio_i` on rising MDC.
- R11: MDC has a period of MDC_DIV clocks (default 8) and stays low while idle. `mdio_o` changes only when MDC falls, never while MDC is high.
- R12: `busy` goes high in the cycle after a command is accepted and drops when the command completes. A control write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 data, 2 feature) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| busy | output | 1 | Frame in flight |
| cmd_err | output | 1 | One-cycle pulse on an unusable command word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume three things about the inputs:
- The register address is always one of the four selects.
- The PHY drives `mdio_i` only while `mdio_oe` is low, and changes it only on falling MDC.
- A completion never arrives while the front end is idle.

The bench's behavioural PHY meets the second assumption by updating its output only on falling MDC, and only during the data phase of a read. The bench's driver issues register writes on falling system-clock edges. It waits for `busy` to drop before issuing the next command, except for the one deliberate write that checks a command is ignored while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W        = 16;
    localparam int ADDR_W        = 5;
    localparam int WORD_W        = 32;
    localparam int FRAME_BITS    = 64;
    localparam int PREAMBLE_BITS = 32;
    localparam int TA_IDX        = 46;
    localparam int DATA_IDX      = 48;

    localparam int FEAT_LAYOUT_BIT = 31;
    localparam int NEW_FIRE_BIT    = 15;
    localparam int NEW_C22_BIT     = 12;
    localparam int LEG_RD_BIT      = 26;
    localparam int LEG_WR_BIT      = 27;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    typedef enum logic {
        LAYOUT_LEGACY = 1'b0,
        LAYOUT_NEW    = 1'b1
    } layout_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_FEAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;

    typedef struct packed {
        logic      start;
        logic      err;
        mdio_cmd_t cmd;
    } cmd_decode_t;

    // Turn a control word into a frame request according to the layout.
    function automatic cmd_decode_t decode_cmd(layout_e lay, logic [WORD_W-1:0] ctl,
                                               logic [WORD_W-1:0] dat);
        cmd_decode_t d;
        d = '0;
        d.cmd.regad = ctl[4:0];
        if (lay == LAYOUT_NEW) begin
            d.cmd.phy   = ctl[9:5];
            d.cmd.wdata = ctl[31:16];
            if (ctl[NEW_C22_BIT] && ctl[NEW_FIRE_BIT]) begin
                if (ctl[11:10] == OPC_WRITE) begin
                    d.start = 1'b1;
                end else if (ctl[11:10] == OPC_READ) begin
                    d.start       = 1'b1;
                    d.cmd.is_read = 1'b1;
                end else begin
                    d.err = 1'b1;
                end
            end
        end else begin
            d.cmd.phy   = ctl[25:21];
            d.cmd.wdata = dat[15:0];
            if (ctl[LEG_WR_BIT]) begin
                d.start = 1'b1;
            end else if (ctl[LEG_RD_BIT]) begin
                d.start       = 1'b1;
                d.cmd.is_read = 1'b1;
            end else begin
                d.err = 1'b1;
            end
        end
        return d;
    endfunction

    // Full serial image of a frame, bit 63 leaves first.
    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
        logic [1:0]        opc;
        logic [DATA_W-1:0] payload;
        opc     = c.is_read ? OPC_READ : OPC_WRITE;
        payload = c.is_read ? '1 : c.wdata;
        return {{PREAMBLE_BITS{1'b1}}, 2'b01, opc, c.phy, c.regad, 2'b10, payload};
    endfunction

    // Command bits to drop when a frame finishes.
    function automatic logic [WORD_W-1:0] clear_cmd_bits(layout_e lay, logic [WORD_W-1:0] ctl,
                                                         logic was_read);
        logic [WORD_W-1:0] r;
        r = ctl;
        if (lay == LAYOUT_NEW) begin
            r[NEW_FIRE_BIT] = 1'b0;
        end else if (was_read) begin
            r[LEG_RD_BIT] = 1'b0;
        end else begin
            r[LEG_WR_BIT] = 1'b0;
        end
        return r;
    endfunction

    // Placement of read data in the data register.
    function automatic logic [WORD_W-1:0] merge_read(layout_e lay, logic [DATA_W-1:0] rd);
        return (lay == LAYOUT_NEW) ? {16'h0000, rd} : {rd, 16'h0000};
    endfunction

endpackage

// File: rtl/mdc_strobe_gen.sv
module mdc_strobe_gen #(
    parameter int MDC_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_stb_o,
    output logic fall_stb_o
);
    localparam int HALF  = MDC_DIV / 2;
    localparam int CNT_W = (MDC_DIV > 2) ? $clog2(MDC_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else begin
            if (cnt_q == CNT_W'(MDC_DIV - 1)) begin
                cnt_q <= '0;
                mdc_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(HALF - 1)) begin
                    mdc_q <= 1'b1;
                end
            end
        end
    end

    assign mdc_o      = mdc_q;
    assign rise_stb_o = run_i && (cnt_q == CNT_W'(HALF));
    assign fall_stb_o = run_i && (cnt_q == CNT_W'(MDC_DIV - 1));

    AST_MDC_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !mdc_q) else $error("mdc high after stop");  // R11
    AST_MDC_HIGH_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        rise_stb_o |-> mdc_q) else $error("sample strobe while mdc low");  // R11

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  mdio_cmd_t         cmd_i,
    input  logic              rise_stb_i,
    input  logic              fall_stb_i,
    input  logic              mdio_i,
    output logic              active_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IDX_W = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shift_q;
    logic [IDX_W-1:0]      idx_q;
    logic [IDX_W-1:0]      idx_nxt;
    logic                  active_q;
    logic                  read_q;
    logic                  oe_q;
    logic                  done_q;
    logic [DATA_W-1:0]     rd_q;

    assign idx_nxt = idx_q + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= '1;
            idx_q    <= '0;
            active_q <= 1'b0;
            read_q   <= 1'b0;
            oe_q     <= 1'b0;
            done_q   <= 1'b0;
            rd_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start_i) begin
                    active_q <= 1'b1;
                    shift_q  <= build_frame(cmd_i);
                    idx_q    <= '0;
                    read_q   <= cmd_i.is_read;
                    oe_q     <= 1'b1;
                    rd_q     <= '0;
                end
            end else begin
                if (rise_stb_i && read_q && (idx_q >= IDX_W'(DATA_IDX))) begin
                    rd_q <= {rd_q[DATA_W-2:0], mdio_i};
                end
                if (fall_stb_i) begin
                    if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                        oe_q     <= 1'b0;
                        shift_q  <= '1;
                    end else begin
                        shift_q <= {shift_q[FRAME_BITS-2:0], 1'b1};
                        idx_q   <= idx_nxt;
                        if (read_q && (idx_nxt >= IDX_W'(TA_IDX))) begin
                            oe_q <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign active_o  = active_q;
    assign mdio_o    = shift_q[FRAME_BITS-1];
    assign mdio_oe_o = oe_q;
    assign done_o    = done_q;
    assign rdata_o   = rd_q;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !active_q) else $error("start while frame runs");  // R12
    AST_WRITE_KEEPS_OE: assert property (@(posedge clk) disable iff (rst)
        active_q && !read_q |-> oe_q) else $error("write frame released mdio");  // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done longer than a cycle");  // R12

endmodule

// File: rtl/mdio_reg_front.sv
module mdio_reg_front
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              start_o,
    output mdio_cmd_t         cmd_o,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rd_data_i
);
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] feat_q;
    logic              busy_q;
    logic              err_q;
    layout_e           lay_q;
    logic              read_q;

    reg_sel_e          sel;
    layout_e           cur_lay;
    cmd_decode_t       dec;
    logic              ctl_wr;
    logic [WORD_W-1:0] ctl_store;

    always_comb begin
        sel       = reg_sel_e'(addr_i);
        cur_lay   = layout_e'(feat_q[FEAT_LAYOUT_BIT]);
        dec       = decode_cmd(cur_lay, wdata_i, data_q);
        ctl_wr    = wr_i && (sel == SEL_CTRL) && !busy_q;
        ctl_store = wdata_i;
        if (dec.err && (cur_lay == LAYOUT_NEW)) begin
            ctl_store[NEW_FIRE_BIT] = 1'b0;
        end
    end

    assign start_o = ctl_wr && dec.start;
    assign cmd_o   = dec.cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
            feat_q <= '0;
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            lay_q  <= LAYOUT_LEGACY;
            read_q <= 1'b0;
        end else begin
            err_q <= ctl_wr && dec.err;
            if (wr_i && (sel == SEL_FEAT)) begin
                feat_q <= wdata_i;
            end
            if (done_i) begin
                ctrl_q <= clear_cmd_bits(lay_q, ctrl_q, read_q);
                if (read_q) begin
                    data_q <= merge_read(lay_q, rd_data_i);
                end
                busy_q <= 1'b0;
            end else begin
                if (ctl_wr) begin
                    ctrl_q <= ctl_store;
                    if (dec.start) begin
                        busy_q <= 1'b1;
                        lay_q  <= cur_lay;
                        read_q <= dec.cmd.is_read;
                    end
                end
                if (wr_i && (sel == SEL_DATA)) begin
                    data_q <= wdata_i;
                end
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata_o = ctrl_q;
            SEL_DATA: rdata_o = data_q;
            SEL_FEAT: rdata_o = feat_q;
            default:  rdata_o = '0;
        endcase
    end

    assign busy_o = busy_q;
    assign err_o  = err_q;

    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_i |-> busy_q) else $error("completion while idle");  // R12
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !busy_q) else $error("busy held after completion");  // R12
    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !busy_q) else $error("error with frame started");  // R4
    AST_FIRE_DROPS: assert property (@(posedge clk) disable iff (rst)
        done_i && (lay_q == LAYOUT_NEW) |=> !ctrl_q[NEW_FIRE_BIT]) else $error("fire kept");  // R2

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int MDC_DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        cmd_err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start;
    mdio_cmd_t         cmd;
    logic              done;
    logic [DATA_W-1:0] rd_data;
    logic              active;
    logic              rise_stb;
    logic              fall_stb;

    mdio_reg_front u_front (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .busy_o    (busy),
        .err_o     (cmd_err),
        .start_o   (start),
        .cmd_o     (cmd),
        .done_i    (done),
        .rd_data_i (rd_data)
    );

    mdc_strobe_gen #(.MDC_DIV(MDC_DIV)) u_mdc (
        .clk        (clk),
        .rst        (rst),
        .run_i      (active),
        .mdc_o      (mdc),
        .rise_stb_o (rise_stb),
        .fall_stb_o (fall_stb)
    );

    mdio_frame_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .cmd_i      (cmd),
        .rise_stb_i (rise_stb),
        .fall_stb_i (fall_stb),
        .mdio_i     (mdio_i),
        .active_o   (active),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe),
        .done_o     (done),
        .rdata_o    (rd_data)
    );

    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        mdc && $past(mdc) |-> $stable(mdio_o)) else $error("mdio moved with mdc high");  // R11
    AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc) else $error("mdc toggling while idle");  // R11

endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, cmd_err, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int frames_seen = 0;
    bit finished = 0;

    typedef struct {
        bit        rd;
        bit [4:0]  phy;
        bit [4:0]  ra;
        bit [15:0] wd;
    } exp_t;
    exp_t exp_q[$];

    logic [15:0] phy_mem [32];
    logic [63:0] cap = '0;
    logic [63:0] oe_hist = '0;
    int          bitcnt = 0;
    logic [4:0]  hdr_reg = '0;
    logic        hdr_read = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_ctrl #(.MDC_DIV(DIV)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .cmd_err(cmd_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Behavioural PHY and scoreboard monitor
    always @(posedge mdc) begin
        cap     = {cap[62:0], mdio_o};
        oe_hist = {oe_hist[62:0], mdio_oe};
        bitcnt++;
        if (bitcnt == 46) begin
            hdr_reg  = cap[4:0];
            hdr_read = (cap[11:10] == 2'b10);
        end
        if (bitcnt == 64) begin
            exp_t e;
            frames_seen++;
            bitcnt = 0;
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected frame", cap[31:0], 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(cap[63:32] == 32'hFFFF_FFFF, "R10 preamble", cap[63:32], 32'hFFFF_FFFF);
                check(cap[31:30] == 2'b01, "R10 start code", {30'h0, cap[31:30]}, 32'h1);
                check(cap[29:28] == (e.rd ? 2'b10 : 2'b01), "R10 opcode",
                      {30'h0, cap[29:28]}, {30'h0, (e.rd ? 2'b10 : 2'b01)});
                check({cap[27:23], cap[22:18]} == {e.phy, e.ra}, "R2 R6 address fields",
                      {22'h0, cap[27:18]}, {22'h0, e.phy, e.ra});
                if (!e.rd) begin
                    check(cap[17:16] == 2'b10, "R10 write turnaround", {30'h0, cap[17:16]}, 32'h2);
                    check(cap[15:0] == e.wd, "R2 R6 write data", {16'h0, cap[15:0]}, {16'h0, e.wd});
                    check(oe_hist == '1, "R10 write oe", oe_hist[31:0], 32'hFFFF_FFFF);
                    phy_mem[cap[22:18]] = cap[15:0];
                end else begin
                    check(oe_hist[17:0] == '0 && oe_hist[63:18] == '1, "R10 read oe release",
                          {14'h0, oe_hist[17:0]}, 32'h0);
                end
            end
        end
    end

    always @(negedge mdc) begin
        if (hdr_read && bitcnt >= 48 && bitcnt < 64)
            mdio_i = phy_mem[hdr_reg][63 - bitcnt];
        else
            mdio_i = 1'b1;
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] new_word(input logic [15:0] d, input bit fire, input bit c22,
                                             input logic [1:0] op, input logic [4:0] phy,
                                             input logic [4:0] ra);
        return {d, fire, 2'b00, c22, op, phy, ra};
    endfunction

    function automatic logic [31:0] leg_word(input bit wr, input bit rd, input logic [4:0] phy,
                                             input logic [4:0] ra);
        return {4'h0, wr, rd, phy, 16'h0, ra};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, w;
        int fs;
        realtime t0;
        exp_t e;
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h1111) ^ 16'h5A0F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        reg_read(2'd0, v); check(v == 0, "R1 reset ctrl", v, 0);
        reg_read(2'd1, v); check(v == 0, "R1 reset data", v, 0);
        reg_read(2'd2, v); check(v == 0, "R1 reset feature", v, 0);
        check(!busy && !mdc && !mdio_oe, "R11 idle pins", {29'h0, busy, mdc, mdio_oe}, 0);

        // R1: feature stores all bits, selects new layout
        reg_write(2'd2, 32'h8000_00A5);
        reg_read(2'd2, v); check(v == 32'h8000_00A5, "R1 feature readback", v, 32'h8000_00A5);

        // R2: new-layout write, plus R12/R11 during the frame
        w = new_word(16'hBEEF, 1, 1, 2'b01, 5'h0A, 5'h03);
        e = '{rd: 0, phy: 5'h0A, ra: 5'h03, wd: 16'hBEEF}; exp_q.push_back(e);
        reg_write(2'd0, w);
        check(busy, "R12 busy after accept", {31'h0, busy}, 1);
        @(posedge mdc); t0 = $realtime; @(posedge mdc);
        check(($realtime - t0) == DIV * CLK_PERIOD, "R11 mdc period",
              32'(int'(($realtime - t0) / CLK_PERIOD)), DIV);
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, v); check(v == w, "R12 ctrl write ignored while busy", v, w);
        wait_idle();
        reg_read(2'd0, v); check(v == (w & ~32'h8000), "R2 fire cleared", v, w & ~32'h8000);

        // R3: new-layout reads
        e = '{rd: 1, phy: 5'h0A, ra: 5'h03, wd: 0}; exp_q.push_back(e);
        reg_write(2'd0, new_word(16'h0, 1, 1, 2'b10, 5'h0A, 5'h03));
        wait_idle();
        reg_read(2'd1, v); check(v == 32'h0000_BEEF, "R3 read data low half", v, 32'h0000_BEEF);
        phy_mem[17] = 16'hA5C3;
        e = '{rd: 1, phy: 5'h1F, ra: 5'd17, wd: 0}; exp_q.push_back(e);
        reg_write(2'd0, new_word(16'hFFFF, 1, 1, 2'b10, 5'h1F, 5'd17));
        wait_idle();
        reg_read(2'd1, v); check(v == 32'h0000_A5C3, "R3 R10 read msb first", v, 32'h0000_A5C3);
        reg_read(2'd0, v); check(v[15] == 0, "R3 fire cleared", v, v & ~32'h8000);

        // R4: invalid opcodes
        fs = frames_seen;
        w = new_word(16'h1234, 1, 1, 2'b00, 5'h01, 5'h02);
        reg_write(2'd0, w);
        check(cmd_err && !busy, "R4 error pulse op00", {30'h0, cmd_err, busy}, 32'h2);
        reg_read(2'd0, v); check(v == (w & ~32'h8000), "R4 fire cleared op00", v, w & ~32'h8000);
        check(!cmd_err, "R4 error single cycle", {31'h0, cmd_err}, 0);
        reg_write(2'd0, new_word(16'h1234, 1, 1, 2'b11, 5'h01, 5'h02));
        check(cmd_err && !busy, "R4 error pulse op11", {30'h0, cmd_err, busy}, 32'h2);
        idle_cycles(80 * DIV);
        check(frames_seen == fs, "R4 no frame", frames_seen, fs);

        // R5: ignored words
        w = new_word(16'h4321, 1, 0, 2'b01, 5'h01, 5'h02);
        reg_write(2'd0, w);
        check(!cmd_err && !busy, "R5 flag clear ignored", {30'h0, cmd_err, busy}, 0);
        reg_read(2'd0, v); check(v == w, "R5 stored unchanged", v, w);
        w = new_word(16'h4321, 0, 1, 2'b10, 5'h01, 5'h02);
        reg_write(2'd0, w);
        check(!cmd_err && !busy, "R5 fire clear ignored", {30'h0, cmd_err, busy}, 0);
        idle_cycles(80 * DIV);
        check(frames_seen == fs, "R5 no frame", frames_seen, fs);

        // Legacy layout
        reg_write(2'd2, 32'h0000_0000);
        reg_write(2'd1, 32'h1234_5A5A);
        e = '{rd: 0, phy: 5'h13, ra: 5'd7, wd: 16'h5A5A}; exp_q.push_back(e);
        w = leg_word(1, 0, 5'h13, 5'd7);
        reg_write(2'd0, w);
        wait_idle();
        reg_read(2'd0, v); check(v == (w & ~(32'h1 << 27)), "R6 write bit cleared", v, w & ~(32'h1 << 27));

        e = '{rd: 1, phy: 5'h13, ra: 5'd7, wd: 0}; exp_q.push_back(e);
        reg_write(2'd0, leg_word(0, 1, 5'h13, 5'd7));
        wait_idle();
        reg_read(2'd1, v); check(v == 32'h5A5A_0000, "R7 read data high half", v, 32'h5A5A_0000);
        reg_read(2'd0, v); check(v[26] == 0, "R7 read bit cleared", v, v & ~(32'h1 << 26));

        // R8: both command bits
        fs = frames_seen;
        reg_write(2'd1, 32'h0000_C0DE);
        e = '{rd: 0, phy: 5'h02, ra: 5'd9, wd: 16'hC0DE}; exp_q.push_back(e);
        w = leg_word(1, 1, 5'h02, 5'd9);
        reg_write(2'd0, w);
        wait_idle();
        idle_cycles(80 * DIV);
        reg_read(2'd0, v); check(v == (w & ~(32'h1 << 27)), "R8 read bit kept", v, w & ~(32'h1 << 27));
        check(frames_seen == fs + 1, "R8 single frame", frames_seen, fs + 1);

        // R9: no command bit
        fs = frames_seen;
        reg_write(2'd0, leg_word(0, 0, 5'h02, 5'd9));
        check(cmd_err && !busy, "R9 error pulse", {30'h0, cmd_err, busy}, 32'h2);
        idle_cycles(80 * DIV);
        check(frames_seen == fs, "R9 no frame", frames_seen, fs);
        check(exp_q.size() == 0, "R10 all frames seen", exp_q.size(), 0);

        finish_run();
    end
endmodule